// File: doc/BRIEF.md
# Hashed Frame-Indexed Translation Lookup

This block translates a virtual page number into a physical address using a table that has exactly one slot for each physical page frame. The slot number is also the frame number. A requested virtual page number is folded by a hash into a slot index. The slot is read from an internal memory, and the virtual page tag stored there is compared with the request. A matching, present entry produces the physical address, which is the slot's frame number followed by the untouched page offset. A matching entry whose page is not resident reports a page fault. A mismatched or empty slot reports a miss, which the surrounding system must resolve from its full page table.

A separate write port loads, replaces or invalidates slots. The lookup path is a two-stage pipeline and accepts one request every clock cycle. The first stage reads the memory synchronously, so it maps onto block RAM. The second stage compares the entry and registers the response. Chaining of colliding pages and any traffic to secondary storage are left to the surrounding system.

Top module: `ipt_lookup`

## Requirements
- R1: The slot index is the low IDX_W bits of the bitwise XOR of the upper half req_vpn[19:10] and the lower half req_vpn[9:0] (default VPN_W=20, IDX_W=6).
- R2: On a hit, rsp_pa equals {slot index, req_off}: bits [17:12] hold the frame (slot) number and bits [11:0] hold the offset of that request, unchanged.
- R3: A hit is reported when the slot is valid, its stored tag equals the full requested virtual page number, and its present bit is 1.
- R4: A fault is reported when the slot is valid and its tag matches but its present bit is 0; rsp_pa is then zero.
- R5: A miss is reported when the slot is invalid or its stored tag differs from the request, including a different page that hashes to the same slot; rsp_pa is then zero.
- R6: Each request raises rsp_valid exactly two clock edges after the edge that samples req_valid, with exactly one of rsp_hit, rsp_fault, rsp_miss high. Without a request, all four are low.
- R7: Requests on consecutive cycles are all answered, one per cycle, in issue order.
- R8: When wr_en is high, slot wr_idx takes {wr_valid, wr_present, wr_tag} at the clock edge. Writing wr_valid=0 makes later lookups of that slot miss.
- R9: A lookup sampled on the same edge as a write to its slot sees the old contents of the slot. Lookups sampled after that edge see the new contents.
- R10: A synchronous active-high rst clears every slot's valid flag and all response outputs, so lookups after reset miss until slots are written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vpn | input | 20 | Virtual page number to translate |
| req_off | input | 12 | Page offset carried to the physical address |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 6 | Slot (frame) number to write |
| wr_valid | input | 1 | Valid flag written to the slot |
| wr_present | input | 1 | Resident flag written to the slot |
| wr_tag | input | 20 | Virtual page tag written to the slot |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Translation found and page resident |
| rsp_fault | output | 1 | Translation found but page not resident |
| rsp_miss | output | 1 | No translation in the slot |
| rsp_pa | output | 18 | Physical address on a hit, zero otherwise |

## Verification
The bench targets two pages that collide on one slot. A design that compared only the hash, or only part of the tag, would report a hit for the intruder. The top slot (index 63) and slot 0 are probed, and a hash that dropped bits would fail to reach them. A write and a lookup are issued to the same slot on the same edge. A write-first memory would answer with the new, invalidated contents instead of the old hit. The bench also checks back-to-back requests and a reset applied after the table is loaded. A pipeline that lost or reordered responses, or a reset that left valid flags set, would show a stale hit.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

  localparam int DEF_VPN_W = 20;
  localparam int DEF_OFF_W = 12;
  localparam int DEF_IDX_W = 6;

  typedef enum logic [1:0] {
    OUT_NONE  = 2'd0,
    OUT_HIT   = 2'd1,
    OUT_FAULT = 2'd2,
    OUT_MISS  = 2'd3
  } outcome_e;

endpackage

// File: rtl/ipt_front.sv
module ipt_front #(
  parameter int VPN_W = 20,
  parameter int OFF_W = 12,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [OFF_W-1:0] req_off,
  output logic [IDX_W-1:0] hash_idx,
  output logic             s1_valid,
  output logic [VPN_W-1:0] s1_vpn,
  output logic [OFF_W-1:0] s1_off,
  output logic [IDX_W-1:0] s1_idx
);

  localparam int LO_W = VPN_W / 2;
  localparam int HI_W = VPN_W - LO_W;

  // Fold upper half onto lower half, keep IDX_W bits
  for (genvar i = 0; i < IDX_W; i++) begin : g_fold
    if (i < LO_W) begin : g_both
      assign hash_idx[i] = req_vpn[LO_W+i] ^ req_vpn[i];
    end else if (i < HI_W) begin : g_upper
      assign hash_idx[i] = req_vpn[LO_W+i];
    end else begin : g_zero
      assign hash_idx[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= req_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      s1_vpn <= req_vpn;
      s1_off <= req_off;
      s1_idx <= hash_idx;
    end
  end

  AST_STAGE1_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> s1_valid); // R6

endmodule

// File: rtl/ipt_table.sv
module ipt_table #(
  parameter int TAG_W = 20,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic             wr_present,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_present,
  output logic [TAG_W-1:0] rd_tag
);

  localparam int DEPTH = 1 << IDX_W;

  // Resident flag and tag live in RAM; valid flags in flops for reset
  logic [TAG_W:0]   mem [DEPTH];
  logic [DEPTH-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= {wr_present, wr_tag};
    end
  end

  // Read-first: registered read sees contents before a same-edge write
  always_ff @(posedge clk) begin
    if (rd_en) begin
      {rd_present, rd_tag} <= mem[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
    end else if (rd_en) begin
      rd_valid <= valid_q[rd_idx];
    end
  end

  AST_INVALIDATE_STICKS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_valid) |=> !valid_q[$past(wr_idx)]); // R8

  AST_RESET_EMPTY: assert property (@(posedge clk)
    $past(rst) |-> (valid_q == '0)); // R10

endmodule

// File: rtl/ipt_resolve.sv
module ipt_resolve
  import ipt_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int OFF_W = 12,
  parameter int IDX_W = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   s1_valid,
  input  logic [VPN_W-1:0]       s1_vpn,
  input  logic [OFF_W-1:0]       s1_off,
  input  logic [IDX_W-1:0]       s1_idx,
  input  logic                   ent_valid,
  input  logic                   ent_present,
  input  logic [VPN_W-1:0]       ent_tag,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic                   rsp_fault,
  output logic                   rsp_miss,
  output logic [IDX_W+OFF_W-1:0] rsp_pa
);

  localparam int PA_W = IDX_W + OFF_W;

  outcome_e         kind;
  logic             tag_eq;
  logic [PA_W-1:0]  pa_next;

  always_comb begin
    tag_eq  = ent_valid && (ent_tag == s1_vpn);
    kind    = OUT_NONE;
    pa_next = '0;
    if (s1_valid) begin
      if (!tag_eq) begin
        kind = OUT_MISS;
      end else if (ent_present) begin
        kind    = OUT_HIT;
        pa_next = {s1_idx, s1_off};
      end else begin
        kind = OUT_FAULT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= s1_valid;
      rsp_hit   <= (kind == OUT_HIT);
      rsp_fault <= (kind == OUT_FAULT);
      rsp_miss  <= (kind == OUT_MISS);
      rsp_pa    <= pa_next;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_hit, rsp_fault, rsp_miss}) == 1)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> ({rsp_hit, rsp_fault, rsp_miss} == 3'b000)); // R6

  AST_PA_ZERO_UNLESS_HIT: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_pa == '0)); // R5

  AST_HIT_NEEDS_PRESENT: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> (rsp_hit == ($past(ent_present) && !rsp_miss))); // R3

  AST_FAULT_NEEDS_TAG: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> $past(ent_valid && !ent_present)); // R4

endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
  parameter int VPN_W = ipt_pkg::DEF_VPN_W,
  parameter int OFF_W = ipt_pkg::DEF_OFF_W,
  parameter int IDX_W = ipt_pkg::DEF_IDX_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [VPN_W-1:0]       req_vpn,
  input  logic [OFF_W-1:0]       req_off,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic                   wr_valid,
  input  logic                   wr_present,
  input  logic [VPN_W-1:0]       wr_tag,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic                   rsp_fault,
  output logic                   rsp_miss,
  output logic [IDX_W+OFF_W-1:0] rsp_pa
);

  logic [IDX_W-1:0] hash_idx;
  logic             s1_valid;
  logic [VPN_W-1:0] s1_vpn;
  logic [OFF_W-1:0] s1_off;
  logic [IDX_W-1:0] s1_idx;
  logic             ent_valid;
  logic             ent_present;
  logic [VPN_W-1:0] ent_tag;

  ipt_front #(.VPN_W(VPN_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_front (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_vpn   (req_vpn),
    .req_off   (req_off),
    .hash_idx  (hash_idx),
    .s1_valid  (s1_valid),
    .s1_vpn    (s1_vpn),
    .s1_off    (s1_off),
    .s1_idx    (s1_idx)
  );

  ipt_table #(.TAG_W(VPN_W), .IDX_W(IDX_W)) u_table (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_valid   (wr_valid),
    .wr_present (wr_present),
    .wr_tag     (wr_tag),
    .rd_en      (req_valid),
    .rd_idx     (hash_idx),
    .rd_valid   (ent_valid),
    .rd_present (ent_present),
    .rd_tag     (ent_tag)
  );

  ipt_resolve #(.VPN_W(VPN_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_resolve (
    .clk         (clk),
    .rst         (rst),
    .s1_valid    (s1_valid),
    .s1_vpn      (s1_vpn),
    .s1_off      (s1_off),
    .s1_idx      (s1_idx),
    .ent_valid   (ent_valid),
    .ent_present (ent_present),
    .ent_tag     (ent_tag),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_fault   (rsp_fault),
    .rsp_miss    (rsp_miss),
    .rsp_pa      (rsp_pa)
  );

  AST_TWO_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> ##1 rsp_valid); // R6

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && !s1_valid) |=> ##1 !rsp_valid); // R7

  AST_HIT_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> ##1 (!rsp_hit || (rsp_pa[OFF_W-1:0] == $past(req_off, 2)))); // R2

endmodule

// File: tb/tb_ipt_lookup.sv
`timescale 1ns/1ps
module tb_ipt_lookup;

  localparam int VPN_W = 20;
  localparam int OFF_W = 12;
  localparam int IDX_W = 6;
  localparam int PA_W  = IDX_W + OFF_W;

  localparam logic [1:0] K_HIT   = 2'd0;
  localparam logic [1:0] K_FAULT = 2'd1;
  localparam logic [1:0] K_MISS  = 2'd2;

  localparam logic [19:0] VA = 20'h12345;
  localparam logic [19:0] VB = 20'h12345 ^ 20'h00401; // same slot as VA
  localparam logic [19:0] VC = 20'h0ABCD;
  localparam logic [19:0] VD = 20'hFFC00;             // slot 63
  localparam logic [19:0] VE = 20'h00000;             // slot 0
  localparam logic [19:0] VF = 20'h55555;             // slot 0, other tag

  // {vpn, offset, expected kind}
  localparam logic [33:0] VEC [6] = '{
    {VA, 12'hABC, K_HIT},
    {VB, 12'h001, K_MISS},
    {VC, 12'h7FF, K_FAULT},
    {VD, 12'hFFF, K_HIT},
    {VE, 12'h000, K_HIT},
    {VF, 12'h123, K_MISS}
  };

  logic             clk = 1'b0;
  logic             rst;
  logic             req_valid;
  logic [VPN_W-1:0] req_vpn;
  logic [OFF_W-1:0] req_off;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_valid;
  logic             wr_present;
  logic [VPN_W-1:0] wr_tag;
  logic             rsp_valid;
  logic             rsp_hit;
  logic             rsp_fault;
  logic             rsp_miss;
  logic [PA_W-1:0]  rsp_pa;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ipt_lookup #(.VPN_W(VPN_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vpn(req_vpn),
    .req_off(req_off), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_present(wr_present), .wr_tag(wr_tag), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_miss(rsp_miss),
    .rsp_pa(rsp_pa)
  );

  function automatic logic [IDX_W-1:0] slot_of(logic [19:0] v);
    logic [9:0] f;
    f = v[19:10] ^ v[9:0];
    return f[IDX_W-1:0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Checks a response that is currently on the outputs
  task automatic chk_rsp(string req, logic [1:0] kind, logic [19:0] v, logic [11:0] off);
    logic [PA_W-1:0] exp_pa;
    exp_pa = (kind == K_HIT) ? {slot_of(v), off} : '0;
    chk(req, {28'd0, rsp_valid, rsp_hit, rsp_fault, rsp_miss},
        {28'd0, 1'b1, kind == K_HIT, kind == K_FAULT, kind == K_MISS});
    chk(req, {14'd0, rsp_pa}, {14'd0, exp_pa});
  endtask

  task automatic write_slot(logic [IDX_W-1:0] idx, logic v, logic p, logic [19:0] tag);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_valid = v; wr_present = p; wr_tag = tag;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(string req, logic [19:0] v, logic [11:0] off, logic [1:0] kind);
    @(negedge clk);
    req_valid = 1'b1; req_vpn = v; req_off = off;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk_rsp(req, kind, v, off);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_vpn = '0; req_off = '0;
    wr_en = 1'b0; wr_idx = '0; wr_valid = 1'b0; wr_present = 1'b0; wr_tag = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: outputs cleared in reset, lookups miss on an empty table
    chk("R10 reset outputs", {27'd0, rsp_valid, rsp_hit, rsp_fault, rsp_miss, |rsp_pa}, 32'd0);
    lookup("R10 empty table", VA, 12'h010, K_MISS);

    // Load slots: R8 write port
    write_slot(slot_of(VA), 1'b1, 1'b1, VA);
    write_slot(slot_of(VC), 1'b1, 1'b0, VC);
    write_slot(slot_of(VD), 1'b1, 1'b1, VD);
    write_slot(slot_of(VE), 1'b1, 1'b1, VE);

    // R1 R2 R3 R4 R5: vector walk
    for (int i = 0; i < 6; i++) begin
      lookup("R1/R2/R3/R4/R5 vector", VEC[i][33:14], VEC[i][13:2], VEC[i][1:0]);
    end
    chk("R1 slot 63", {26'd0, slot_of(VD)}, 32'd63);

    // R6: idle cycle after response
    @(negedge clk);
    chk("R6 idle quiet", {28'd0, rsp_valid, rsp_hit, rsp_fault, rsp_miss}, 32'd0);

    // R7: back-to-back requests
    @(negedge clk);
    req_valid = 1'b1; req_vpn = VA; req_off = 12'h111;
    @(negedge clk);
    req_vpn = VC; req_off = 12'h222;
    @(negedge clk);
    req_vpn = VB; req_off = 12'h333;
    chk_rsp("R7 first of three", K_HIT, VA, 12'h111);
    @(negedge clk);
    req_valid = 1'b0;
    chk_rsp("R7 second of three", K_FAULT, VC, 12'h222);
    @(negedge clk);
    chk_rsp("R7 third of three", K_MISS, VB, 12'h333);

    // R9: same-edge write invalidating VA's slot, lookup sees old entry
    @(negedge clk);
    wr_en = 1'b1; wr_idx = slot_of(VA); wr_valid = 1'b0; wr_present = 1'b1; wr_tag = VA;
    req_valid = 1'b1; req_vpn = VA; req_off = 12'h444;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    chk_rsp("R9 read-first old entry", K_HIT, VA, 12'h444);
    lookup("R8 invalidated slot", VA, 12'h444, K_MISS);

    // R8/R5: collider replaces slot
    write_slot(slot_of(VB), 1'b1, 1'b1, VB);
    lookup("R8 replaced slot new tag", VB, 12'h555, K_HIT);
    lookup("R5 old tag after replace", VA, 12'h555, K_MISS);
    // R4: page becomes resident
    write_slot(slot_of(VC), 1'b1, 1'b1, VC);
    lookup("R3 now resident", VC, 12'h666, K_HIT);

    // R10: reset after loading clears valid flags
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 outputs after reset", {27'd0, rsp_valid, rsp_hit, rsp_fault, rsp_miss, |rsp_pa}, 32'd0);
    lookup("R10 loaded slot after reset", VD, 12'h777, K_MISS);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule